// File: doc/BRIEF.md
# Dual Result FIFO with Interrupt Status Unit

This block sits between the conversion engines of a data acquisition subsystem and the processor bus. Two producers each push 32-bit tagged result words into their own first-in first-out queue. Software drains a queue by reading its data address, and each read removes one entry. Reading the queue's count address returns its occupancy without disturbing it. Each queue has a programmable threshold register that holds the desired fill level minus one.

The interrupt unit holds sticky raw event bits for queue threshold, overrun and underflow, plus event pulses for end of sequence, out-of-range, pen-up and two pen-down flavours. An enable mask is modified through separate OR-in and AND-out addresses. The masked status is the raw status gated by the mask, and software acknowledges a bit by writing a one to it. A single level-sensitive interrupt line is the OR of all masked bits.

Reads are returned on `bus_rdata` at the clock edge that follows the read strobe. Writes take effect at the edge where the write strobe is high. The external reset is asynchronous and active low, and it is released through a two-stage synchroniser.

Top module: `result_fifo_irq`

## Requirements
- R1: After reset, both occupancies read 0, raw status (0x24), masked status (0x28) and the enable mask (0x2C) read 0, and `irq` is low.
- R2: A read strobe at 0x100 pops queue 0 and a read strobe at 0x200 pops queue 1. The popped word appears on `bus_rdata` after the next rising edge, and words leave each queue in the order they were pushed.
- R3: Reading 0xE4 (queue 0) or 0xF0 (queue 1) returns the occupancy in bits [6:0] with all upper bits zero, and it does not pop.
- R4: A queue holds at most 64 entries. A push into a full queue is dropped, the occupancy stays at 64, and raw bit 3 (queue 0) or bit 6 (queue 1) is set.
- R5: A pop from an empty queue returns 0 and sets raw bit 4 (queue 0) or bit 7 (queue 1).
- R6: The threshold registers sit at 0xE8 (queue 0) and 0xF4 (queue 1), are 7 bits wide and reset to 0. Raw bit 2 (queue 0) or bit 5 (queue 1) is set on the edge after the occupancy exceeds the threshold value. It keeps being set while that condition holds, so an acknowledge does not clear it until the queue drains below the level.
- R7: The event inputs set sticky raw bits as follows: asynchronous pen-down sets bit 0, end of sequence sets bit 1, out-of-range sets bit 8, pen-up sets bit 9 and synchronous pen-down sets bit 10.
- R8: Writing 0x2C ORs the ones of `bus_wdata[10:0]` into the enable mask, and writing 0x30 removes them. Reading either address returns the mask.
- R9: Reading 0x28 returns raw status AND mask. Reading 0x24 returns raw status regardless of the mask.
- R10: Writing a one to a bit at 0x28 clears that raw bit, and writing a zero leaves it unchanged. An event arriving in the same cycle as the clear wins, and the bit stays set.
- R11: `irq` is high exactly when some masked bit is set. It falls at the edge of the acknowledging write.
- R12: Traffic on one queue never changes the other queue's occupancy or contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push0_valid | input | 1 | Push strobe, queue 0 |
| push0_data | input | 32 | Entry for queue 0 |
| push1_valid | input | 1 | Push strobe, queue 1 |
| push1_data | input | 32 | Entry for queue 1 |
| evt_pen_async | input | 1 | Asynchronous pen-down event pulse |
| evt_seq_done | input | 1 | End of sequence event pulse |
| evt_out_of_range | input | 1 | Out-of-range event pulse |
| evt_pen_up | input | 1 | Pen-up event pulse |
| evt_pen_sync | input | 1 | Synchronous pen-down event pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the edge following `bus_rd` |
| irq | output | 1 | Level interrupt, OR of masked status |

## Verification
A corrupted pointer or occupancy shows up at the first pop after it happens. The word on `bus_rdata` no longer matches the scoreboard's queue front, or an empty queue returns a stale word instead of zero. A wrong raw, enable or threshold bit becomes visible one register read later, and on `irq` at the very next edge. For this reason the bench reads status right after each event and each acknowledge, and it compares every popped word as it appears. Overrun is driven past the full level on the second queue so that a lost drop shows up as a count of 65 or a shifted data sequence.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  localparam int IRQ_W = 11;
  localparam int AW    = 12;

  // interrupt bit positions; software decodes these
  localparam int B_PEN_ASYNC = 0;
  localparam int B_SEQ_DONE  = 1;
  localparam int B_FIFO_BASE = 2;   // +0 threshold, +1 overrun, +2 underflow
  localparam int B_FIFO_STEP = 3;
  localparam int B_OOR       = 8;
  localparam int B_PEN_UP    = 9;
  localparam int B_PEN_SYNC  = 10;

  localparam logic [AW-1:0] A_RAW   = 12'h024;
  localparam logic [AW-1:0] A_STAT  = 12'h028;
  localparam logic [AW-1:0] A_ENSET = 12'h02C;
  localparam logic [AW-1:0] A_ENCLR = 12'h030;

  function automatic logic [AW-1:0] cnt_addr(input int f);
    return 12'h0E4 + AW'(12 * f);
  endfunction

  function automatic logic [AW-1:0] thr_addr(input int f);
    return 12'h0E8 + AW'(12 * f);
  endfunction

  function automatic logic [AW-1:0] data_addr(input int f);
    return AW'(256 * (f + 1));
  endfunction
endpackage

// File: rtl/rfi_fifo.sv
module rfi_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_o,
  output logic             udf_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign ovf_o   = push_i & full_o;
  assign udf_o   = pop_i & empty_o;
  assign count_o = cnt_q;
  assign head_o  = empty_o ? '0 : mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_d;
      if (do_pop)  rd_ptr_q <= rd_ptr_d;
      if (do_push ^ do_pop) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= din_i;
  end
endmodule

// File: rtl/rfi_irq_ctrl.sv
module rfi_irq_ctrl #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         wr_stat_i,
  input  logic         wr_set_i,
  input  logic         wr_clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] raw_q, raw_d, en_q, en_d;
  logic         en_we;

  always_comb begin
    raw_d = raw_q;
    if (wr_stat_i) raw_d = raw_q & ~wdata_i;
    raw_d = raw_d | set_i;          // a fresh event beats an acknowledge
    en_we = wr_set_i | wr_clr_i;
    en_d  = en_q;
    if (wr_set_i)      en_d = en_q | wdata_i;
    else if (wr_clr_i) en_d = en_q & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      raw_q <= raw_d;
      if (en_we) en_q <= en_d;
    end
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign irq_o = |(raw_q & en_q);
endmodule

// File: rtl/result_fifo_irq.sv
module result_fifo_irq #(
  parameter int DEPTH = 64,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push0_valid,
  input  logic [DW-1:0] push0_data,
  input  logic          push1_valid,
  input  logic [DW-1:0] push1_data,
  input  logic          evt_pen_async,
  input  logic          evt_seq_done,
  input  logic          evt_out_of_range,
  input  logic          evt_pen_up,
  input  logic          evt_pen_sync,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [11:0]   bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  import rfi_pkg::*;

  localparam int NF = 2;
  localparam int CW = $clog2(DEPTH) + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             push_v [NF];
  logic [DW-1:0]    push_d [NF];
  logic             pop    [NF];
  logic [DW-1:0]    head   [NF];
  logic [CW-1:0]    cnt    [NF];
  logic             full   [NF];
  logic             empty  [NF];
  logic             ovf    [NF];
  logic             udf    [NF];
  logic [CW-1:0]    thr_q  [NF];
  logic             thr_hit[NF];
  logic [IRQ_W-1:0] set_vec, raw, en, irq_wdata;
  logic             wr_stat, wr_en_set, wr_en_clr;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic             unused_wdata_hi;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign push_v[0] = push0_valid;
  assign push_v[1] = push1_valid;
  assign push_d[0] = push0_data;
  assign push_d[1] = push1_data;

  for (genvar f = 0; f < NF; f++) begin : g_q
    logic thr_we;

    assign pop[f]     = bus_rd && (bus_addr == data_addr(f));
    assign thr_we     = bus_wr && (bus_addr == thr_addr(f));
    assign thr_hit[f] = cnt[f] > thr_q[f];

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)  thr_q[f] <= '0;
      else if (thr_we)  thr_q[f] <= bus_wdata[CW-1:0];
    end

    rfi_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .push_i  (push_v[f]),
      .din_i   (push_d[f]),
      .pop_i   (pop[f]),
      .head_o  (head[f]),
      .count_o (cnt[f]),
      .full_o  (full[f]),
      .empty_o (empty[f]),
      .ovf_o   (ovf[f]),
      .udf_o   (udf[f])
    );
  end

  always_comb begin
    set_vec              = '0;
    set_vec[B_PEN_ASYNC] = evt_pen_async;
    set_vec[B_SEQ_DONE]  = evt_seq_done;
    set_vec[B_OOR]       = evt_out_of_range;
    set_vec[B_PEN_UP]    = evt_pen_up;
    set_vec[B_PEN_SYNC]  = evt_pen_sync;
    for (int f = 0; f < NF; f++) begin
      set_vec[B_FIFO_BASE + B_FIFO_STEP*f]     = thr_hit[f];
      set_vec[B_FIFO_BASE + B_FIFO_STEP*f + 1] = ovf[f];
      set_vec[B_FIFO_BASE + B_FIFO_STEP*f + 2] = udf[f];
    end
  end

  assign wr_stat         = bus_wr && (bus_addr == A_STAT);
  assign wr_en_set       = bus_wr && (bus_addr == A_ENSET);
  assign wr_en_clr       = bus_wr && (bus_addr == A_ENCLR);
  assign irq_wdata       = bus_wdata[IRQ_W-1:0];
  assign unused_wdata_hi = ^bus_wdata[DW-1:IRQ_W];

  rfi_irq_ctrl #(.W(IRQ_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_i     (set_vec),
    .wr_stat_i (wr_stat),
    .wr_set_i  (wr_en_set),
    .wr_clr_i  (wr_en_clr),
    .wdata_i   (irq_wdata),
    .raw_o     (raw),
    .en_o      (en),
    .irq_o     (irq)
  );

  always_comb begin
    rdata_d = '0;
    if (bus_addr == A_RAW)                                   rdata_d = DW'(raw);
    else if (bus_addr == A_STAT)                             rdata_d = DW'(raw & en);
    else if (bus_addr == A_ENSET || bus_addr == A_ENCLR)     rdata_d = DW'(en);
    for (int f = 0; f < NF; f++) begin
      if (bus_addr == cnt_addr(f))  rdata_d = DW'(cnt[f]);
      if (bus_addr == thr_addr(f))  rdata_d = DW'(thr_q[f]);
      if (bus_addr == data_addr(f)) rdata_d = head[f];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (bus_rd)  rdata_q <= rdata_d;
  end
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/rfi_checker.sv
module rfi_checker #(
  parameter int DEPTH = 64,
  parameter int CW    = 7,
  parameter int W     = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push0,
  input logic          full0,
  input logic          pop0,
  input logic          empty0,
  input logic [CW-1:0] cnt0,
  input logic [W-1:0]  raw,
  input logic [W-1:0]  en,
  input logic          irq,
  input logic          wr_stat,
  input logic [W-1:0]  wdata,
  input logic [W-1:0]  set_vec
);
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt0 <= CW'(DEPTH));

  assert_overrun_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push0 && full0) |=> raw[3]);

  assert_underflow_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop0 && empty0) |=> raw[4]);

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[1] && !set_vec[1]) |=> !raw[1]);

  assert_sticky_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[0] && !(wr_stat && wdata[0])) |=> raw[0]);

  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

bind result_fifo_irq rfi_checker #(
  .DEPTH (DEPTH),
  .CW    (CW),
  .W     (rfi_pkg::IRQ_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .push0   (push_v[0]),
  .full0   (full[0]),
  .pop0    (pop[0]),
  .empty0  (empty[0]),
  .cnt0    (cnt[0]),
  .raw     (raw),
  .en      (en),
  .irq     (irq),
  .wr_stat (wr_stat),
  .wdata   (irq_wdata),
  .set_vec (set_vec)
);

// File: tb/sim_result_fifo_irq.sv
module sim_result_fifo_irq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        push0_valid, push1_valid;
  logic [31:0] push0_data, push1_data;
  logic        evt_pen_async, evt_seq_done, evt_out_of_range, evt_pen_up, evt_pen_sync;
  logic        bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  always #4 clk = ~clk;   // 125 MHz

  result_fifo_irq u0 (
    .clk(clk), .rst_n(rst_n),
    .push0_valid(push0_valid), .push0_data(push0_data),
    .push1_valid(push1_valid), .push1_data(push1_data),
    .evt_pen_async(evt_pen_async), .evt_seq_done(evt_seq_done),
    .evt_out_of_range(evt_out_of_range), .evt_pen_up(evt_pen_up),
    .evt_pen_sync(evt_pen_sync),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] sb0[$];
  logic [31:0] sb1[$];
  logic [31:0] mon_exp;
  logic        mon_empty;
  logic [31:0] v;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int f, input logic [31:0] d);
    @(negedge clk);
    if (f == 0) begin push0_valid = 1'b1; push0_data = d; end
    else        begin push1_valid = 1'b1; push1_data = d; end
    @(posedge clk); #2;
    push0_valid = 1'b0;
    push1_valid = 1'b0;
    if (f == 0) begin if (sb0.size() < 64) sb0.push_back(d); end
    else        begin if (sb1.size() < 64) sb1.push_back(d); end
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #2;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input bit with_eos);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    evt_seq_done = with_eos;
    @(posedge clk); #2;
    bus_wr = 1'b0;
    evt_seq_done = 1'b0;
  endtask

  task automatic pulse(input int b);
    @(negedge clk);
    case (b)
      0:  evt_pen_async    = 1'b1;
      1:  evt_seq_done     = 1'b1;
      8:  evt_out_of_range = 1'b1;
      9:  evt_pen_up       = 1'b1;
      default: evt_pen_sync = 1'b1;
    endcase
    @(posedge clk); #2;
    evt_pen_async = 1'b0; evt_seq_done = 1'b0; evt_out_of_range = 1'b0;
    evt_pen_up = 1'b0; evt_pen_sync = 1'b0;
  endtask

  // monitor: every data-window read is compared with the scoreboard front
  always begin
    @(posedge clk);
    if (bus_rd && (bus_addr == 12'h100 || bus_addr == 12'h200)) begin
      if (bus_addr == 12'h100) begin
        mon_empty = (sb0.size() == 0);
        mon_exp   = mon_empty ? 32'h0 : sb0.pop_front();
      end else begin
        mon_empty = (sb1.size() == 0);
        mon_exp   = mon_empty ? 32'h0 : sb1.pop_front();
      end
      #2;
      if (mon_empty) chk("R5 pop of empty queue returns zero", bus_rdata, mon_exp);
      else           chk("R2 popped word in push order", bus_rdata, mon_exp);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    push0_valid = 1'b0; push1_valid = 1'b0; push0_data = '0; push1_data = '0;
    evt_pen_async = 1'b0; evt_seq_done = 1'b0; evt_out_of_range = 1'b0;
    evt_pen_up = 1'b0; evt_pen_sync = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 irq low after reset", {31'b0, irq}, 32'h0);
    bus_read(12'h0E4, v); chk("R1 queue 0 count", v, 32'h0);
    bus_read(12'h0F0, v); chk("R1 queue 1 count", v, 32'h0);
    bus_read(12'h024, v); chk("R1 raw status", v, 32'h0);
    bus_read(12'h028, v); chk("R1 masked status", v, 32'h0);
    bus_read(12'h02C, v); chk("R1 enable mask", v, 32'h0);
    bus_read(12'h0E8, v); chk("R1 R6 threshold reset", v, 32'h0);

    // R6 threshold
    bus_write(12'h0E8, 32'd3, 1'b0);
    bus_write(12'h0F4, 32'd127, 1'b0);
    for (int i = 0; i < 3; i++) push(0, 32'hA000_0000 + i);
    idle(1);
    bus_read(12'h024, v); chk("R6 occupancy equal to threshold sets nothing", v, 32'h0);
    push(0, 32'hA000_0003);
    idle(1);
    bus_read(12'h024, v); chk("R6 occupancy above threshold", v, 32'h004);
    bus_write(12'h028, 32'h004, 1'b0);
    bus_read(12'h024, v); chk("R6 acknowledge while level holds", v, 32'h004);

    // R3 / R12 counts
    bus_read(12'h0E4, v); chk("R3 queue 0 occupancy", v, 32'd4);
    bus_read(12'h0E4, v); chk("R3 count read does not pop", v, 32'd4);
    bus_read(12'h0F0, v); chk("R12 queue 1 untouched", v, 32'd0);

    // R2 / R5 drain and underflow
    for (int i = 0; i < 4; i++) bus_read(12'h100, v);
    bus_read(12'h100, v);
    bus_read(12'h024, v); chk("R5 underflow flag queue 0", v, 32'h014);

    // R10 acknowledge
    bus_write(12'h028, 32'h004, 1'b0);
    bus_read(12'h024, v); chk("R10 write one clears", v, 32'h010);
    bus_write(12'h028, 32'h000, 1'b0);
    bus_read(12'h024, v); chk("R10 write zero no effect", v, 32'h010);

    // R8 / R9 / R11 masking
    chk("R11 irq low with empty mask", {31'b0, irq}, 32'h0);
    bus_read(12'h028, v); chk("R9 masked status with empty mask", v, 32'h0);
    bus_write(12'h02C, 32'h010, 1'b0);
    chk("R11 irq rises with enabled bit", {31'b0, irq}, 32'h1);
    bus_read(12'h028, v); chk("R9 masked status", v, 32'h010);
    bus_write(12'h02C, 32'h001, 1'b0);
    bus_read(12'h030, v); chk("R8 mask after two sets", v, 32'h011);
    bus_write(12'h030, 32'h001, 1'b0);
    bus_read(12'h02C, v); chk("R8 mask after clear", v, 32'h010);
    bus_write(12'h028, 32'h010, 1'b0);
    chk("R11 irq falls on acknowledge", {31'b0, irq}, 32'h0);

    // R4 overrun on queue 1
    for (int i = 0; i < 66; i++) push(1, 32'hB000_0000 + i);
    bus_read(12'h0F0, v); chk("R4 occupancy capped at depth", v, 32'd64);
    bus_read(12'h024, v); chk("R4 overrun flag queue 1", v, 32'h040);
    bus_read(12'h0E4, v); chk("R12 queue 0 unaffected", v, 32'd0);
    chk("R11 irq low for masked-off overrun", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 64; i++) bus_read(12'h200, v);
    bus_read(12'h0F0, v); chk("R2 queue 1 drained", v, 32'd0);

    // R7 events
    pulse(1);
    bus_read(12'h024, v); chk("R7 end of sequence bit 1", v, 32'h042);
    pulse(0);
    pulse(8);
    pulse(9);
    pulse(10);
    bus_read(12'h024, v); chk("R7 all pen and range events", v, 32'h743);
    bus_write(12'h028, 32'h002, 1'b1);
    bus_read(12'h024, v); chk("R10 event beats same-cycle clear", v, 32'h743);
    bus_write(12'h028, 32'h7FF, 1'b0);
    bus_read(12'h024, v); chk("R10 clear all", v, 32'h0);

    // R5 underflow queue 1
    bus_read(12'h200, v);
    bus_read(12'h024, v); chk("R5 underflow flag queue 1", v, 32'h080);

    idle(2);
    report();
    $finish;
  end
endmodule